// File: doc/BRIEF.md
# Shared Data Memory Window with Ownership Lock

This block gives a host a narrow, indirect path into a word-organised data memory that an embedded controller also uses. The host programs a control register with a byte address and two stepping flags. Each later access to the data register then moves one 32-bit word at the current address. After a write the address steps by one word when the write-step flag is set. After a read it steps when the read-step flag is set. A long upload is therefore one control write followed by a burst of data writes.

Both sides share a lock register that holds a requester token. A requester writes its own nonzero token and reads the register back. It owns the window only if it sees its own value, and otherwise it tries again. Writing zero frees the lock. The host only reaches the memory while the lock is held by a token it wrote itself. Any other data access is dropped and raises a sticky violation flag. The controller side is reduced to a lock-request port, and the memory is a small internal synchronous RAM.

Top module: `mem_window_port`

## Requirements
- R1: After reset the lock holds 0, the address is word 0, both stepping flags are clear, the violation flag is low and no read data is valid.
- R2: A nonzero token written to the lock (host register select 2, or the controller lock port) while it holds 0 is taken, and readback returns it from the next cycle. If host and controller both write nonzero in the same cycle while the lock is free, the host token is taken.
- R3: A nonzero token write from either side while the lock is nonzero is ignored, and the held value is unchanged.
- R4: A write of 0 to the lock from either side frees it in the next cycle. A release in the same cycle as a nonzero write takes precedence.
- R5: A host write to the control register (select 0) loads bit 24 as the write-step flag and bit 25 as the read-step flag. Byte-address bits [AW+1:2] load the word address, where AW = log2(DEPTH). The two lowest bits and all higher bits are ignored. Control readback returns the flags at bits 24/25, the current word address times 4 in the low bits, and zeros elsewhere.
- R6: A host data write (select 1) while the host owns the lock stores the word at the current address. The address then advances by one word only if the write-step flag is set.
- R7: A host data read while the host owns the lock returns the stored word. The address then advances by one word only if the read-step flag is set.
- R8: Stepping past the last word wraps the address to word 0.
- R9: A host data access while the host does not own the lock returns 0 on a read, leaves the memory and the address unchanged, and sets the violation flag, which stays set until reset.
- R10: Every host read returns its data with host_rvalid one cycle after the request. Reads of the reserved select 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host register access this cycle |
| host_we | input | 1 | 1 write, 0 read |
| host_sel | input | 2 | 0 control, 1 data, 2 lock, 3 reserved |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| ctl_lock_we | input | 1 | Controller writes the lock this cycle |
| ctl_lock_token | input | TOKW | Controller token, 0 releases |
| lock_value | output | TOKW | Current lock content, for controller readback |
| viol_flag | output | 1 | Sticky blocked-access flag |

## Verification
The bench builds the block with DEPTH = 16 and TOKW = 4. A stepping burst then runs past the last word within a few cycles, so wraparound is exercised. Byte addresses above the memory size can also be written to check that they fold back. A 4-bit token keeps distinct host and controller identifiers, along with the same-cycle acquire and release races, cheap to drive one by one.

// File: rtl/mwp_pkg.sv
// Package: shared selector codes, lock-side tags and control bit positions
// for the memory window port. Assumes 32-bit host registers.
package mwp_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_LOCK = 2'd2,
        SEL_RSVD = 2'd3
    } sel_e;

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CTL  = 1'b1
    } side_e;

    localparam int WSTEP_BIT = 24;
    localparam int RSTEP_BIT = 25;
endpackage

// File: rtl/mwp_lock.sv
// Ownership lock: holds one token and records which side wrote it.
// Assumes at most one write per side per cycle. Any zero write releases.
// When the lock is free, the host wins a same-cycle acquire race.
module mwp_lock
    import mwp_pkg::*;
#(
    parameter int TOKW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_we,
    input  logic [TOKW-1:0] h_tok,
    input  logic            c_we,
    input  logic [TOKW-1:0] c_tok,
    output logic [TOKW-1:0] owner,
    output logic            host_owns
);
    logic [TOKW-1:0] owner_q;
    side_e           side_q;
    logic            release_req;

    // any zero write from either side frees the lock
    assign release_req = (h_we && h_tok == '0) || (c_we && c_tok == '0);

    // token register: release, else acquire only when free (host first)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            side_q  <= SIDE_HOST;
        end else if (release_req) begin
            owner_q <= '0;
        end else if (owner_q == '0) begin
            if (h_we) begin
                owner_q <= h_tok;
                side_q  <= SIDE_HOST;
            end else if (c_we) begin
                owner_q <= c_tok;
                side_q  <= SIDE_CTL;
            end
        end
    end

    assign owner     = owner_q;
    assign host_owns = (owner_q != '0) && (side_q == SIDE_HOST);

    assert_hold_when_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q != '0 && !release_req) |=> $stable(owner_q));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> owner_q == '0);

    assert_host_acquire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == '0 && h_we && h_tok != '0 && !release_req)
        |=> (owner_q == $past(h_tok) && host_owns));
endmodule

// File: rtl/mwp_addr.sv
// Address and mode register: word address plus write/read stepping flags.
// Assumes a power-of-two depth so that stepping wraps by itself.
module mwp_addr
    import mwp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_we,
    input  logic [DW-1:0]            ctrl_wdata,
    input  logic                     step_wr,
    input  logic                     step_rd,
    output logic [$clog2(DEPTH)-1:0] word_addr,
    output logic                     wstep,
    output logic                     rstep
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] word_q;
    logic          wstep_q;
    logic          rstep_q;
    logic          advance;

    // step only for the direction whose flag is set
    assign advance = (step_wr && wstep_q) || (step_rd && rstep_q);

    // control load, else optional post-access step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            wstep_q <= 1'b0;
            rstep_q <= 1'b0;
        end else if (ctrl_we) begin
            word_q  <= ctrl_wdata[AW+1:2];
            wstep_q <= ctrl_wdata[WSTEP_BIT];
            rstep_q <= ctrl_wdata[RSTEP_BIT];
        end else if (advance) begin
            word_q <= word_q + 1'b1;
        end
    end

    assign word_addr = word_q;
    assign wstep     = wstep_q;
    assign rstep     = rstep_q;

    assert_write_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_wr && wstep_q && !ctrl_we) |=> word_q == AW'($past(word_q) + 1'b1));

    assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rd && !rstep_q && !ctrl_we) |=> $stable(word_q));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && word_q == '1 && !ctrl_we) |=> word_q == '0);
endmodule

// File: rtl/mwp_ram.sv
// Single-port synchronous RAM model with a one-cycle read.
// Assumes a read and a write never fall in the same cycle.
module mwp_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // storage write and registered read
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mem_window_port.sv
// Memory window port: host registers for control, data and lock on top of
// the lock, the address/mode register and the RAM. Data accesses are gated
// by host ownership. Reads return one cycle after the request.
// Assumes DEPTH is a power of two with log2(DEPTH)+2 <= 24.
module mem_window_port
    import mwp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int TOKW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [1:0]      host_sel,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    output logic            host_rvalid,
    input  logic            ctl_lock_we,
    input  logic [TOKW-1:0] ctl_lock_token,
    output logic [TOKW-1:0] lock_value,
    output logic            viol_flag
);
    localparam int DW = 32;
    localparam int AW = $clog2(DEPTH);

    sel_e          sel;
    logic          host_owns;
    logic          data_acc;
    logic          data_wr_ok;
    logic          data_rd_ok;
    logic [AW-1:0] word_addr;
    logic          wstep;
    logic          rstep;
    logic [DW-1:0] ram_q;
    logic [DW-1:0] ctrl_word;
    logic [DW-1:0] reg_mux;
    logic [DW-1:0] reg_q;
    sel_e          rd_sel_q;
    logic          rd_owned_q;
    logic          rvalid_q;
    logic          viol_q;

    assign sel        = sel_e'(host_sel);
    assign data_acc   = host_req && sel == SEL_DATA;
    assign data_wr_ok = data_acc && host_we && host_owns;
    assign data_rd_ok = data_acc && !host_we && host_owns;

    mwp_lock #(.TOKW(TOKW)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_we      (host_req && host_we && sel == SEL_LOCK),
        .h_tok     (host_wdata[TOKW-1:0]),
        .c_we      (ctl_lock_we),
        .c_tok     (ctl_lock_token),
        .owner     (lock_value),
        .host_owns (host_owns)
    );

    mwp_addr #(.DEPTH(DEPTH), .DW(DW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (host_req && host_we && sel == SEL_CTRL),
        .ctrl_wdata (host_wdata),
        .step_wr    (data_wr_ok),
        .step_rd    (data_rd_ok),
        .word_addr  (word_addr),
        .wstep      (wstep),
        .rstep      (rstep)
    );

    mwp_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (data_wr_ok),
        .re    (data_rd_ok),
        .addr  (word_addr),
        .wdata (host_wdata),
        .rdata (ram_q)
    );

    // control readback word: flags and byte address
    always_comb begin
        ctrl_word            = '0;
        ctrl_word[WSTEP_BIT] = wstep;
        ctrl_word[RSTEP_BIT] = rstep;
        ctrl_word[AW+1:0]    = {word_addr, 2'b00};
    end

    // register readback selection
    always_comb begin
        case (sel)
            SEL_CTRL: reg_mux = ctrl_word;
            SEL_LOCK: reg_mux = {{(DW-TOKW){1'b0}}, lock_value};
            default:  reg_mux = '0;
        endcase
    end

    // read pipeline stage aligned with the RAM read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q   <= 1'b0;
            rd_sel_q   <= SEL_CTRL;
            rd_owned_q <= 1'b0;
            reg_q      <= '0;
        end else begin
            rvalid_q <= host_req && !host_we;
            if (host_req && !host_we) begin
                rd_sel_q   <= sel;
                rd_owned_q <= host_owns;
                reg_q      <= reg_mux;
            end
        end
    end

    // sticky record of blocked data accesses
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else if (data_acc && !host_owns) viol_q <= 1'b1;
    end

    assign host_rdata  = (rd_sel_q == SEL_DATA) ? (rd_owned_q ? ram_q : '0) : reg_q;
    assign host_rvalid = rvalid_q;
    assign viol_flag   = viol_q;

    assert_blocked_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !host_we && !host_owns) |=> (host_rvalid && host_rdata == '0));

    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);

    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we) |=> host_rvalid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_we) |=> !host_rvalid);
endmodule

// File: tb/tb_mem_window_port.sv
module tb_mem_window_port;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int TOKW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_req = 1'b0, host_we = 1'b0;
    logic [1:0]      host_sel = '0;
    logic [31:0]     host_wdata = '0;
    logic [31:0]     host_rdata;
    logic            host_rvalid;
    logic            ctl_lock_we = 1'b0;
    logic [TOKW-1:0] ctl_lock_token = '0;
    logic [TOKW-1:0] lock_value;
    logic            viol_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_window_port #(.DEPTH(DEPTH), .TOKW(TOKW)) dut (.*);

    int    errors = 0, checks = 0;
    string tag = "R1";

    // reference model state
    int          m_owner;
    bit          m_host_side;
    int          m_addr;
    bit          m_wstep, m_rstep, m_viol;
    logic [31:0] m_mem [DEPTH];
    bit          m_known [DEPTH];
    bit          e_rv, e_known;
    logic [31:0] e_rd;

    task automatic fail(string what, logic [31:0] act, logic [31:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // compare outputs with the model, once per clock away from the edge
    task automatic compare();
        checks++;
        if (host_rvalid !== e_rv) fail("rvalid", 32'(host_rvalid), 32'(e_rv));
        if (e_rv && e_known) begin
            checks++;
            if (host_rdata !== e_rd) fail("rdata", host_rdata, e_rd);
        end
        checks++;
        if (lock_value !== TOKW'(m_owner)) fail("lock", 32'(lock_value), 32'(m_owner));
        checks++;
        if (viol_flag !== m_viol) fail("viol", 32'(viol_flag), 32'(m_viol));
    endtask

    // one bus cycle: check previous results, drive, advance the model
    task automatic cyc(bit req, bit we, int sel, logic [31:0] wd, bit cwe, int ctok);
        bit owned, hz, cz;
        compare();
        host_req = req; host_we = we; host_sel = 2'(sel); host_wdata = wd;
        ctl_lock_we = cwe; ctl_lock_token = TOKW'(ctok);
        owned = (m_owner != 0) && m_host_side;
        e_rv = req && !we;
        e_known = 1'b1;
        e_rd = '0;
        if (e_rv) begin
            if (sel == 0) e_rd = (32'(m_rstep) << 25) | (32'(m_wstep) << 24) | 32'(m_addr * 4);
            else if (sel == 2) e_rd = 32'(m_owner);
            else if (sel == 1 && owned) begin
                e_rd = m_mem[m_addr];
                e_known = m_known[m_addr];
            end
        end
        if (req && sel == 1) begin
            if (!owned) m_viol = 1'b1;
            else if (we) begin
                m_mem[m_addr] = wd; m_known[m_addr] = 1'b1;
                if (m_wstep) m_addr = (m_addr + 1) % DEPTH;
            end else if (m_rstep) m_addr = (m_addr + 1) % DEPTH;
        end
        if (req && we && sel == 0) begin
            m_wstep = wd[24]; m_rstep = wd[25];
            m_addr = int'((wd >> 2) % DEPTH);
        end
        hz = req && we && sel == 2 && wd[TOKW-1:0] == '0;
        cz = cwe && ctok == 0;
        if (hz || cz) m_owner = 0;
        else if (m_owner == 0) begin
            if (req && we && sel == 2) begin m_owner = int'(wd[TOKW-1:0]); m_host_side = 1'b1; end
            else if (cwe) begin m_owner = ctok; m_host_side = 1'b0; end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hw(int sel, logic [31:0] d); cyc(1, 1, sel, d, 0, 0); endtask
    task automatic hr(int sel);                 cyc(1, 0, sel, '0, 0, 0); endtask
    task automatic cl(int tok);                 cyc(0, 0, 0, '0, 1, tok); endtask
    task automatic idle();                      cyc(0, 0, 0, '0, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_owner = 0; m_host_side = 1'b1; m_addr = 0;
        m_wstep = 0; m_rstep = 0; m_viol = 0; e_rv = 0; e_known = 1; e_rd = '0;
        for (int i = 0; i < DEPTH; i++) m_known[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through readback
        tag = "R1"; hr(0); hr(2); idle();

        // R10: reserved select reads zero
        tag = "R10"; hr(3); idle();

        // R2 / R6: host acquires, writes word 0, releases
        tag = "R2"; hw(2, 1); hr(2);
        tag = "R6"; hw(0, 32'h0); hw(1, 32'hAAAA_0000); hr(0);
        tag = "R4"; hw(2, 0); hr(2);

        // R9: blocked accesses while the lock is free
        tag = "R9"; hw(1, 32'h55); hr(1); hr(0); idle();

        // R3: controller holds, host write ignored, host data blocked
        tag = "R3"; cl(5); hw(2, 1); hr(2); hr(1); cl(7); idle();
        // R4: controller releases
        tag = "R4"; cl(0); hr(2); idle();

        // R2: host reacquires with token 2, data word 0 kept through blocked write
        tag = "R2"; hw(2, 2); hr(2); cl(3); hr(2);
        tag = "R9"; hw(0, 32'h0); hr(1); idle();

        // R6 / R8: stepping write burst past the end
        tag = "R8"; hw(0, 32'h0100_0000);
        for (int i = 0; i < DEPTH + 2; i++) hw(1, 32'h1000_0000 + 32'(i * 3));
        hr(0); idle();

        // R7: stepping read burst, wrapping
        tag = "R7"; hw(0, 32'h0200_0000 | 32'((DEPTH - 2) * 4));
        for (int i = 0; i < 5; i++) hr(1);
        hr(0);
        // R7: read without read-step stays on the same word
        hw(0, 32'h0100_0000 | 32'h14); hr(1); hr(1); hr(0); idle();
        // R6: write without write-step overwrites the same word
        tag = "R6"; hw(0, 32'h0200_0008); hw(1, 32'hBEEF_0001); hw(1, 32'hBEEF_0002); hr(0);
        hr(1); hr(0); idle();

        // R5: low byte bits and address bits above the memory are ignored
        tag = "R5"; hw(0, 32'h0300_000B); hr(0);
        hw(0, 32'h00FF_FF47); hr(0); hr(1); idle();

        // R4: release in the same cycle as a controller acquire
        tag = "R4"; cyc(1, 1, 2, 32'h0, 1, 6); hr(2); idle();
        // R2: simultaneous acquire, host wins
        tag = "R2"; cyc(1, 1, 2, 32'h9, 1, 6); hr(2); hr(1); idle();
        // R4: host releases, then blocked read
        tag = "R4"; hw(2, 0); hr(2);
        tag = "R9"; hr(1); idle();

        // R1: reset clears lock, address, flags and violation
        tag = "R1";
        rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
        m_owner = 0; m_addr = 0; m_wstep = 0; m_rstep = 0; m_viol = 0; e_rv = 0;
        hr(0); hr(2); idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule